// File: doc/BRIEF.md
# Dual-Engine Debug Halt Controller

This block keeps the execution state of two microengines that share one debug interface. Each engine is idle, running a thread, halted, or executing a single debug step. The controller merges several halt sources for each engine: a decoded halt opcode, a hardware breakpoint hit, a level-sensitive external debug halt and a chip-level debug request. It also applies a twin-halt option, so that one engine entering halt pulls the other engine into halt in the same cycle.

While an engine is halted, the controller drives three outputs for that engine. One gives up its claim on the shared parameter RAM arbiter. One freezes input sampling and filtering, and one gates the timebase clocks; these two act only when the matching debug stop input is high. A visibility bit can only be set while both engines are halted. While it is set, both engines are held in halt and step commands are ignored. Clearing it lets the engines leave halt by themselves.

The microengine datapath, the breakpoint comparators and the programming interface sit outside this block. The block only sees their events and a small set of configuration write strobes.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: In reset, every engine is IDLE and the halted, freeze, RAM-release, timebase-gate and visibility outputs are 0. The chip-request enable resets to 1 and the slot-boundary select resets to 0. If the chip debug request is high when reset is released, each engine is HALT after the first clock edge and never enters RUN.
- R2: State encoding per engine is IDLE=0, RUN=1, HALT=2, STEP=3, with engine i on eng_state[2i+1:2i]. IDLE moves to RUN when a thread is pending. RUN moves to IDLE on thread end only when no thread is pending; otherwise it stays in RUN.
- R3: A halt opcode, breakpoint hit or external halt in IDLE or RUN moves the engine to HALT at the next edge. This takes priority over starting a pending thread. Several sources in the same cycle give one halt entry.
- R4: With twin-halt set, an engine entering HALT from IDLE or RUN makes every other IDLE or RUN engine enter HALT at the same edge.
- R5: The chip debug request halts an engine only while the enable bit is 1. With the slot-boundary select at 1, it halts an engine only in a cycle where that engine's slot_boundary is high. With the select at 0, it halts immediately.
- R6: A halt caused by an opcode, a breakpoint or twin coupling is held until resume_cmd. An engine leaves HALT once that hold, its external halt and the enabled chip request are all clear and visibility is 0. It returns to RUN if it was inside a thread, and to IDLE otherwise.
- R7: step_cmd in HALT moves the engine to STEP for exactly one cycle, after which it returns to HALT.
- R8: Writing visibility to 1 takes effect only when every engine is in HALT. Writing 0 always clears it. While it is 1, a HALT engine stays in HALT and ignores step_cmd.
- R9: In HALT, ram_release is 1. freeze_in follows stop_pins and tbase_gate follows stop_tbase. In every other state all three are 0.
- R10: halted[i] is 1 exactly one cycle after engine i was in HALT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_pending | input | NUM_ENG | A thread is scheduled for the engine |
| thread_end | input | NUM_ENG | End-of-thread event |
| halt_op | input | NUM_ENG | Decoded halt opcode executed |
| ext_halt | input | NUM_ENG | External debug halt request (level) |
| bkpt_hit | input | NUM_ENG | Hardware breakpoint hit |
| step_cmd | input | NUM_ENG | Single-step command |
| resume_cmd | input | NUM_ENG | Clears the held halt cause |
| slot_boundary | input | NUM_ENG | Engine is at a time-slot boundary |
| soc_dbg_req | input | 1 | Chip-level debug request (level) |
| cfg_we | input | 1 | Write strobe for the three configuration bits |
| cfg_soc_en | input | 1 | Chip-request enable value |
| cfg_soc_slot | input | 1 | Slot-boundary select value |
| cfg_twin | input | 1 | Twin-halt value |
| vis_we | input | 1 | Visibility write strobe |
| vis_val | input | 1 | Visibility write value |
| stop_pins | input | 1 | Freeze input sampling while halted |
| stop_tbase | input | 1 | Gate timebase clocks while halted |
| eng_state | output | 2*NUM_ENG | Per-engine state code |
| halted | output | NUM_ENG | Registered halted status |
| freeze_in | output | NUM_ENG | Input sampling and filter freeze |
| ram_release | output | NUM_ENG | Parameter RAM arbitration released |
| tbase_gate | output | NUM_ENG | Timebase clock gate |
| vis_on | output | 1 | Visibility bit |

## Verification
The hardest state to reach is visibility held at 1 with every halt cause already gone, while step commands arrive. Getting there needs both engines in HALT at once: a shared external halt is held on both, visibility is written, and only then are the halts dropped and steps issued. The bench also has to show two rejected visibility writes, one with no engine halted and one with only one engine halted. Twin coupling and the slot-gated chip request are reached by first programming the configuration bits, then pulsing a single source on one engine and watching the other.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_HALT = 2'd2,
    ENG_STEP = 2'd3
  } eng_state_e;
endpackage

// File: rtl/dbg_cfg_regs.sv
module dbg_cfg_regs #(
  parameter int NUM_ENG = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_soc_en,
  input  logic               cfg_soc_slot,
  input  logic               cfg_twin,
  input  logic               vis_we,
  input  logic               vis_val,
  input  logic [NUM_ENG-1:0] eng_in_halt,
  output logic               soc_en_q,
  output logic               soc_slot_q,
  output logic               twin_q,
  output logic               vis_q
);
  logic soc_en_d, soc_slot_d, twin_d, vis_d;
  logic all_halted;

  assign all_halted = &eng_in_halt;

  always_comb begin
    soc_en_d   = soc_en_q;
    soc_slot_d = soc_slot_q;
    twin_d     = twin_q;
    vis_d      = vis_q;
    if (cfg_we) begin
      soc_en_d   = cfg_soc_en;
      soc_slot_d = cfg_soc_slot;
      twin_d     = cfg_twin;
    end
    if (vis_we) begin
      if (!vis_val)        vis_d = 1'b0;
      else if (all_halted) vis_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soc_en_q   <= 1'b1;
      soc_slot_q <= 1'b0;
      twin_q     <= 1'b0;
      vis_q      <= 1'b0;
    end else begin
      soc_en_q   <= soc_en_d;
      soc_slot_q <= soc_slot_d;
      twin_q     <= twin_d;
      vis_q      <= vis_d;
    end
  end
endmodule

// File: rtl/halt_req_merge.sv
module halt_req_merge #(
  parameter int NUM_ENG = 2
) (
  input  logic [NUM_ENG-1:0] halt_op,
  input  logic [NUM_ENG-1:0] ext_halt,
  input  logic [NUM_ENG-1:0] bkpt_hit,
  input  logic [NUM_ENG-1:0] slot_boundary,
  input  logic [NUM_ENG-1:0] eng_active,
  input  logic               soc_dbg_req,
  input  logic               soc_en,
  input  logic               soc_slot,
  input  logic               twin,
  output logic [NUM_ENG-1:0] own_req,
  output logic [NUM_ENG-1:0] couple,
  output logic               soc_hold
);
  logic [NUM_ENG-1:0] soc_now;
  logic [NUM_ENG-1:0] raw_entry;

  assign soc_hold  = soc_dbg_req & soc_en;
  assign soc_now   = {NUM_ENG{soc_hold}} & ({NUM_ENG{~soc_slot}} | slot_boundary);
  assign own_req   = halt_op | ext_halt | bkpt_hit | soc_now;
  assign raw_entry = own_req & eng_active;

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_cpl
    localparam logic [NUM_ENG-1:0] SELF = NUM_ENG'(1) << g;
    assign couple[g] = twin & (|(raw_entry & ~SELF));
  end
endmodule

// File: rtl/eng_halt_fsm.sv
module eng_halt_fsm
  import dbg_halt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sched,
  input  logic       thread_end,
  input  logic       halt_op,
  input  logic       bkpt_hit,
  input  logic       ext_halt,
  input  logic       own_req,
  input  logic       couple,
  input  logic       soc_hold,
  input  logic       resume,
  input  logic       step,
  input  logic       vis,
  input  logic       stop_pins,
  input  logic       stop_tbase,
  output logic [1:0] state,
  output logic       active,
  output logic       in_halt,
  output logic       halted_q,
  output logic       freeze,
  output logic       tbase_gate
);
  eng_state_e st_q, st_d;
  logic latch_q, latch_d;
  logic ins_q, ins_d;
  logic enter, hold;

  assign active  = (st_q == ENG_IDLE) || (st_q == ENG_RUN);
  assign enter   = active & (own_req | couple);
  assign hold    = latch_q | ext_halt | soc_hold;
  assign in_halt = (st_q == ENG_HALT);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ENG_IDLE: begin
        if (enter)      st_d = ENG_HALT;
        else if (sched) st_d = ENG_RUN;
      end
      ENG_RUN: begin
        if (enter)                    st_d = ENG_HALT;
        else if (thread_end && !sched) st_d = ENG_IDLE;
      end
      ENG_HALT: begin
        if (vis)        st_d = ENG_HALT;
        else if (step)  st_d = ENG_STEP;
        else if (!hold) st_d = ins_q ? ENG_RUN : ENG_IDLE;
      end
      ENG_STEP: st_d = ENG_HALT;
      default:  st_d = ENG_IDLE;
    endcase
  end

  always_comb begin
    latch_d = latch_q;
    if (enter && (halt_op || bkpt_hit || couple)) latch_d = 1'b1;
    else if (resume)                              latch_d = 1'b0;
    ins_d = ins_q;
    if (st_d == ENG_RUN)       ins_d = 1'b1;
    else if (st_d == ENG_IDLE) ins_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ENG_IDLE;
      latch_q  <= 1'b0;
      ins_q    <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      latch_q  <= latch_d;
      ins_q    <= ins_d;
      halted_q <= in_halt;
    end
  end

  assign state      = st_q;
  assign freeze     = in_halt & stop_pins;
  assign tbase_gate = in_halt & stop_tbase;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl #(
  parameter int NUM_ENG = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_ENG-1:0]   sched_pending,
  input  logic [NUM_ENG-1:0]   thread_end,
  input  logic [NUM_ENG-1:0]   halt_op,
  input  logic [NUM_ENG-1:0]   ext_halt,
  input  logic [NUM_ENG-1:0]   bkpt_hit,
  input  logic [NUM_ENG-1:0]   step_cmd,
  input  logic [NUM_ENG-1:0]   resume_cmd,
  input  logic [NUM_ENG-1:0]   slot_boundary,
  input  logic                 soc_dbg_req,
  input  logic                 cfg_we,
  input  logic                 cfg_soc_en,
  input  logic                 cfg_soc_slot,
  input  logic                 cfg_twin,
  input  logic                 vis_we,
  input  logic                 vis_val,
  input  logic                 stop_pins,
  input  logic                 stop_tbase,
  output logic [2*NUM_ENG-1:0] eng_state,
  output logic [NUM_ENG-1:0]   halted,
  output logic [NUM_ENG-1:0]   freeze_in,
  output logic [NUM_ENG-1:0]   ram_release,
  output logic [NUM_ENG-1:0]   tbase_gate,
  output logic                 vis_on
);
  logic               soc_en_q, soc_slot_q, twin_q, vis_q;
  logic [NUM_ENG-1:0] in_halt, active, own_req, couple;
  logic               soc_hold;

  dbg_cfg_regs #(.NUM_ENG(NUM_ENG)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_soc_en  (cfg_soc_en),
    .cfg_soc_slot(cfg_soc_slot),
    .cfg_twin    (cfg_twin),
    .vis_we      (vis_we),
    .vis_val     (vis_val),
    .eng_in_halt (in_halt),
    .soc_en_q    (soc_en_q),
    .soc_slot_q  (soc_slot_q),
    .twin_q      (twin_q),
    .vis_q       (vis_q)
  );

  halt_req_merge #(.NUM_ENG(NUM_ENG)) u_merge (
    .halt_op      (halt_op),
    .ext_halt     (ext_halt),
    .bkpt_hit     (bkpt_hit),
    .slot_boundary(slot_boundary),
    .eng_active   (active),
    .soc_dbg_req  (soc_dbg_req),
    .soc_en       (soc_en_q),
    .soc_slot     (soc_slot_q),
    .twin         (twin_q),
    .own_req      (own_req),
    .couple       (couple),
    .soc_hold     (soc_hold)
  );

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
    eng_halt_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .sched     (sched_pending[g]),
      .thread_end(thread_end[g]),
      .halt_op   (halt_op[g]),
      .bkpt_hit  (bkpt_hit[g]),
      .ext_halt  (ext_halt[g]),
      .own_req   (own_req[g]),
      .couple    (couple[g]),
      .soc_hold  (soc_hold),
      .resume    (resume_cmd[g]),
      .step      (step_cmd[g]),
      .vis       (vis_q),
      .stop_pins (stop_pins),
      .stop_tbase(stop_tbase),
      .state     (eng_state[2*g +: 2]),
      .active    (active[g]),
      .in_halt   (in_halt[g]),
      .halted_q  (halted[g]),
      .freeze    (freeze_in[g]),
      .tbase_gate(tbase_gate[g])
    );
  end

  assign ram_release = in_halt;
  assign vis_on      = vis_q;
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk #(
  parameter int NUM_ENG = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [2*NUM_ENG-1:0] eng_state,
  input logic [NUM_ENG-1:0]   halted,
  input logic [NUM_ENG-1:0]   freeze_in,
  input logic [NUM_ENG-1:0]   ram_release,
  input logic [NUM_ENG-1:0]   tbase_gate,
  input logic                 vis_on
);
  for (genvar g = 0; g < NUM_ENG; g++) begin : g_chk
    a_r7_step_returns: assert property (@(posedge clk) disable iff (!rst_n)
      eng_state[2*g +: 2] == 2'd3 |=> eng_state[2*g +: 2] == 2'd2);
    a_r7_step_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
      eng_state[2*g +: 2] == 2'd3 |-> $past(eng_state[2*g +: 2]) == 2'd2);
    a_r8_vis_keeps_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (vis_on && eng_state[2*g +: 2] == 2'd2) |=> eng_state[2*g +: 2] == 2'd2);
    a_r10_halted_lag: assert property (@(posedge clk) disable iff (!rst_n)
      halted[g] == $past(eng_state[2*g +: 2] == 2'd2));
    a_r9_freeze_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_in[g] || tbase_gate[g]) |-> ram_release[g]);
  end

  a_r8_vis_set_needs_all_halted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vis_on) |-> $past(&ram_release));
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(.NUM_ENG(NUM_ENG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .eng_state  (eng_state),
  .halted     (halted),
  .freeze_in  (freeze_in),
  .ram_release(ram_release),
  .tbase_gate (tbase_gate),
  .vis_on     (vis_on)
);

// File: tb/tb_dbg_halt_ctrl.sv
module tb_dbg_halt_ctrl;
  localparam int NE = 2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [NE-1:0] sched_pending, thread_end, halt_op, ext_halt, bkpt_hit;
  logic [NE-1:0] step_cmd, resume_cmd, slot_boundary;
  logic soc_dbg_req, cfg_we, cfg_soc_en, cfg_soc_slot, cfg_twin;
  logic vis_we, vis_val, stop_pins, stop_tbase;
  logic [2*NE-1:0] eng_state;
  logic [NE-1:0] halted, freeze_in, ram_release, tbase_gate;
  logic vis_on;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_halt_ctrl #(.NUM_ENG(NE)) dut (.*);

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  // behavioural reference state
  int m_st[NE];
  bit m_lat[NE], m_ins[NE], m_hq[NE];
  bit m_vis, m_en, m_slot, m_twin;

  function automatic void model_reset();
    for (int i = 0; i < NE; i++) begin
      m_st[i] = 0; m_lat[i] = 0; m_ins[i] = 0; m_hq[i] = 0;
    end
    m_vis = 0; m_en = 1; m_slot = 0; m_twin = 0;
  endfunction

  function automatic void model_step();
    bit act[NE], ent[NE], pe[NE], req[NE];
    int nst[NE];
    bit soc_lvl, all_h, other;
    soc_lvl = soc_dbg_req && m_en;
    all_h = 1;
    for (int i = 0; i < NE; i++) begin
      act[i] = (m_st[i] == 0) || (m_st[i] == 1);
      req[i] = halt_op[i] || ext_halt[i] || bkpt_hit[i] ||
               (soc_lvl && (!m_slot || slot_boundary[i]));
      pe[i]  = act[i] && req[i];
      if (m_st[i] != 2) all_h = 0;
    end
    for (int i = 0; i < NE; i++) begin
      other = 0;
      for (int j = 0; j < NE; j++) if (j != i && pe[j]) other = 1;
      other = other && m_twin;
      ent[i] = act[i] && (req[i] || other);
      case (m_st[i])
        0: nst[i] = ent[i] ? 2 : (sched_pending[i] ? 1 : 0);
        1: nst[i] = ent[i] ? 2 : ((thread_end[i] && !sched_pending[i]) ? 0 : 1);
        2: begin
          if (m_vis) nst[i] = 2;
          else if (step_cmd[i]) nst[i] = 3;
          else if (!(m_lat[i] || ext_halt[i] || soc_lvl)) nst[i] = m_ins[i] ? 1 : 0;
          else nst[i] = 2;
        end
        default: nst[i] = 2;
      endcase
      m_hq[i] = (m_st[i] == 2);
      if (ent[i] && (halt_op[i] || bkpt_hit[i] || other)) m_lat[i] = 1;
      else if (resume_cmd[i]) m_lat[i] = 0;
      if (nst[i] == 1) m_ins[i] = 1;
      else if (nst[i] == 0) m_ins[i] = 0;
    end
    for (int i = 0; i < NE; i++) m_st[i] = nst[i];
    if (vis_we) begin
      if (!vis_val) m_vis = 0;
      else if (all_h) m_vis = 1;
    end
    if (cfg_we) begin
      m_en = cfg_soc_en; m_slot = cfg_soc_slot; m_twin = cfg_twin;
    end
  endfunction

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < NE; i++) begin
      chk($sformatf("state[%0d]", i), 32'(eng_state[2*i +: 2]), 32'(m_st[i]));
      chk($sformatf("halted[%0d] (R10)", i), 32'(halted[i]), 32'(m_hq[i]));
      chk($sformatf("ram_release[%0d] (R9)", i), 32'(ram_release[i]), 32'(m_st[i] == 2));
      chk($sformatf("freeze_in[%0d] (R9)", i), 32'(freeze_in[i]), 32'((m_st[i] == 2) && stop_pins));
      chk($sformatf("tbase_gate[%0d] (R9)", i), 32'(tbase_gate[i]), 32'((m_st[i] == 2) && stop_tbase));
    end
    chk("vis_on (R8)", 32'(vis_on), 32'(m_vis));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic clear_pulses();
    halt_op = '0; bkpt_hit = '0; step_cmd = '0; resume_cmd = '0;
    thread_end = '0; slot_boundary = '0; cfg_we = 0; vis_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clear_pulses();
    sched_pending = '0; ext_halt = '0; soc_dbg_req = 1;
    cfg_soc_en = 1; cfg_soc_slot = 0; cfg_twin = 0; vis_val = 0;
    stop_pins = 0; stop_tbase = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    // R1: leave reset with chip request high and threads pending
    rst_n = 1; sched_pending = 2'b11;
    cyc(); cyc();
    soc_dbg_req = 0; cyc(); cyc(); cyc();
    // R2: thread end with and without a pending thread
    tag = "R2";
    sched_pending = 2'b10; thread_end = 2'b11; cyc();
    clear_pulses(); cyc();
    sched_pending = 2'b11; cyc(); cyc();
    // R3: external halt, halt opcode, breakpoint over pending start
    tag = "R3"; stop_pins = 1;
    ext_halt = 2'b01; cyc(); cyc();
    ext_halt = 2'b00; cyc(); cyc();
    halt_op = 2'b10; bkpt_hit = 2'b10; ext_halt = 2'b10; cyc();
    clear_pulses(); ext_halt = 0; cyc(); cyc();
    tag = "R6"; resume_cmd = 2'b10; cyc(); clear_pulses(); cyc(); cyc();
    tag = "R3"; stop_tbase = 1;
    sched_pending = 2'b10; thread_end = 2'b01; cyc(); clear_pulses();
    bkpt_hit = 2'b01; sched_pending = 2'b11; cyc(); clear_pulses(); cyc();
    tag = "R6"; resume_cmd = 2'b01; cyc(); clear_pulses(); cyc(); cyc();
    // R4: twin coupling
    tag = "R4"; stop_pins = 0;
    cfg_we = 1; cfg_twin = 1; cfg_soc_en = 1; cfg_soc_slot = 0; cyc(); clear_pulses();
    halt_op = 2'b01; cyc(); clear_pulses(); cyc(); cyc();
    resume_cmd = 2'b11; cyc(); clear_pulses(); cyc(); cyc();
    ext_halt = 2'b11; bkpt_hit = 2'b10; cyc(); clear_pulses(); ext_halt = 0; cyc();
    resume_cmd = 2'b11; cyc(); clear_pulses(); cyc(); cyc();
    // R5: chip request enable and slot boundary
    tag = "R5";
    cfg_we = 1; cfg_twin = 0; cfg_soc_en = 0; cyc(); clear_pulses();
    soc_dbg_req = 1; cyc(); cyc();
    cfg_we = 1; cfg_soc_en = 1; cfg_soc_slot = 1; cyc(); clear_pulses(); cyc();
    slot_boundary = 2'b01; cyc(); clear_pulses(); cyc();
    slot_boundary = 2'b10; cyc(); clear_pulses(); cyc();
    soc_dbg_req = 0; cyc(); cyc(); cyc();
    cfg_we = 1; cfg_soc_slot = 0; cyc(); clear_pulses();
    // R7: single step
    tag = "R7"; stop_pins = 1; stop_tbase = 0;
    ext_halt = 2'b11; cyc(); cyc();
    step_cmd = 2'b01; cyc(); clear_pulses(); cyc();
    step_cmd = 2'b10; cyc(); clear_pulses(); cyc();
    // R8: visibility
    tag = "R8";
    vis_we = 1; vis_val = 1; cyc(); clear_pulses();
    ext_halt = 0; cyc(); cyc();
    step_cmd = 2'b11; cyc(); cyc(); clear_pulses();
    vis_we = 1; vis_val = 0; cyc(); clear_pulses(); cyc(); cyc();
    vis_we = 1; vis_val = 1; cyc(); clear_pulses(); cyc();
    ext_halt = 2'b01; cyc();
    vis_we = 1; vis_val = 1; cyc(); clear_pulses(); cyc();
    ext_halt = 0; cyc(); cyc();
    // mixed random traffic across R2..R10
    tag = "random mix";
    for (int k = 0; k < 400; k++) begin
      clear_pulses();
      sched_pending = 2'($urandom);
      thread_end    = 2'($urandom);
      halt_op       = 2'($urandom) & 2'($urandom) & 2'($urandom);
      bkpt_hit      = 2'($urandom) & 2'($urandom) & 2'($urandom);
      ext_halt      = 2'($urandom) & 2'($urandom);
      step_cmd      = 2'($urandom) & 2'($urandom);
      resume_cmd    = 2'($urandom);
      slot_boundary = 2'($urandom);
      soc_dbg_req   = ($urandom % 6) == 0;
      vis_we        = ($urandom % 5) == 0;
      vis_val       = 1'($urandom);
      cfg_we        = ($urandom % 20) == 0;
      cfg_soc_en    = 1'($urandom);
      cfg_soc_slot  = 1'($urandom);
      cfg_twin      = 1'($urandom);
      stop_pins     = 1'($urandom);
      stop_tbase    = 1'($urandom);
      cyc();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule